// File: doc/BRIEF.md
# Vector Lane Register File

This block holds a bank of wide vector registers (32 registers of 128 bits by default). Each register can be reached as a whole or as one element lane. The lane widths are 8, 16, 32 and 64 bits. A dedicated scalar half-precision mode is also provided. One write port and one read port work in the same cycle. A write changes only the addressed lane. A read returns the chosen lane extended to 64 bits, either with zeros or with copies of its sign bit.

Each port takes a register number, an element size code and a lane index. The size code is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit, 3 for 64-bit, 4 for the full register and 5 for a half-precision scalar. Codes 6 and 7 are unused. A lane index at or beyond the number of lanes of the chosen size is refused. So is any index other than 0 in full or scalar mode, and so is any unused size code. The port's error flag then rises combinationally in the request cycle, and the request has no effect. Read data is registered: it appears on the cycle after the request, together with a valid flag.

Top module: `vlane_file`

## Requirements
- R1: After reset every register reads as all zeros and `rd_valid` is low.
- R2: A legal 8-bit write changes only the addressed byte lane; all other bits of that register and all other registers keep their values.
- R3: Lane k of element width S occupies bits k*S+S-1 down to k*S of the register, so lane 0 holds the least significant bits.
- R4: Legal 16-, 32- and 64-bit writes replace exactly the addressed lane of their width (at most 8, 4 and 2 lanes respectively).
- R5: Size code 4 with index 0 writes all 128 bits from `wr_data`, and a read with it returns all 128 bits unchanged, whatever `rd_signed` says.
- R6: A lane read returns the lane in `rd_data[63:0]`. It is sign-extended when `rd_signed` is 1 and zero-extended otherwise. `rd_data[127:64]` is zero.
- R7: A write whose index is at or above the lane count of its size (16, 8, 4, 2 for codes 0 to 3; only 0 allowed for codes 4 and 5) raises `wr_err` in the same cycle and leaves all register contents unchanged; `wr_err` is low whenever `wr_en` is low.
- R8: A read with an illegal index raises `rd_err` in the same cycle. On the next cycle `rd_valid` is low and `rd_data` keeps its previous value.
- R9: A half-precision scalar write (code 5) puts `wr_data[15:0]` in bits 15:0, clears bits 31:16 and leaves bits 127:32 unchanged; a code 5 read returns bits 15:0 extended as in R6.
- R10: Read data and `rd_valid` appear on the clock edge after a legal request. A read and a write to the same register in the same cycle return the contents from before the write.
- R11: Size codes 6 and 7 are illegal on both ports: they raise the port's error flag and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_reg | input | 5 | Register number to write |
| wr_size | input | 3 | Write element size code |
| wr_idx | input | 5 | Write lane index |
| wr_data | input | 128 | Write data, lane value in the low bits |
| wr_err | output | 1 | Write request refused (same cycle) |
| rd_en | input | 1 | Read request |
| rd_reg | input | 5 | Register number to read |
| rd_size | input | 3 | Read element size code |
| rd_idx | input | 5 | Read lane index |
| rd_signed | input | 1 | 1 = sign-extend the lane, 0 = zero-extend |
| rd_data | output | 128 | Registered read result |
| rd_valid | output | 1 | `rd_data` updated by a legal read on the previous cycle |
| rd_err | output | 1 | Read request refused (same cycle) |

## Verification
A lane merged at the wrong offset, or a write that was not suppressed, sits silently in the register bank. It becomes visible only when that register is read back. So the bench follows each write with a full-width read one cycle later, and compares every bit against an independent model. Sign-extension or lane-select faults show on the very next `rd_data` after the read request. Bounds faults show on the error flags in the request cycle itself, and on the contents of the following full read.

// File: rtl/vlane_pkg.sv
package vlane_pkg;

    typedef enum logic [2:0] {
        ESZ_B8   = 3'd0,
        ESZ_B16  = 3'd1,
        ESZ_B32  = 3'd2,
        ESZ_B64  = 3'd3,
        ESZ_FULL = 3'd4,
        ESZ_HALF = 3'd5
    } esize_e;

    // width of an extended lane result
    localparam int EXT_W      = 64;
    // number of lane sizes that are indexed (8/16/32/64)
    localparam int LANE_SIZES = 4;
    // width of the half-precision scalar payload and its cleared neighbour
    localparam int HALF_W     = 16;

    function automatic int unsigned lanes_of(input logic [2:0] sz, input int unsigned reg_w);
        case (sz)
            ESZ_B8:   lanes_of = reg_w / 8;
            ESZ_B16:  lanes_of = reg_w / 16;
            ESZ_B32:  lanes_of = reg_w / 32;
            ESZ_B64:  lanes_of = reg_w / 64;
            ESZ_FULL: lanes_of = 1;
            ESZ_HALF: lanes_of = 1;
            default:  lanes_of = 0;
        endcase
    endfunction

endpackage

// File: rtl/vlane_bounds.sv
module vlane_bounds
    import vlane_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 128,
    parameter int REG_AW   = 5,
    parameter int IDX_W    = 5
) (
    input  logic              en,
    input  logic [REG_AW-1:0] sel,
    input  logic [2:0]        size,
    input  logic [IDX_W-1:0]  idx,
    output logic              ok,
    output logic              err
);

    localparam int unsigned NR_U = NUM_REGS;
    localparam int unsigned RW_U = REG_W;

    logic idx_ok;
    logic sel_ok;

    always_comb begin
        idx_ok = 32'(idx) < lanes_of(size, RW_U);
        sel_ok = 32'(sel) < NR_U;
        ok     = idx_ok && sel_ok;
        err    = en && !ok;
    end

endmodule

// File: rtl/vlane_merge.sv
module vlane_merge
    import vlane_pkg::*;
#(
    parameter int REG_W = 128,
    parameter int IDX_W = 5
) (
    input  logic [REG_W-1:0] old_val,
    input  logic [2:0]       size,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] data,
    output logic [REG_W-1:0] new_val
);

    // one candidate per indexed lane size
    for (genvar g = 0; g < LANE_SIZES; g++) begin : g_sz
        localparam int EW    = 8 << g;
        localparam int LANES = REG_W / EW;
        localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

        logic [LW-1:0]    lane;
        int unsigned      pos;
        logic [REG_W-1:0] cand;

        always_comb begin
            lane = idx[LW-1:0];
            pos  = 32'(lane) * EW;
            cand = old_val;
            cand[pos +: EW] = data[EW-1:0];
        end
    end

    always_comb begin
        new_val = old_val;
        case (size)
            ESZ_B8:   new_val = g_sz[0].cand;
            ESZ_B16:  new_val = g_sz[1].cand;
            ESZ_B32:  new_val = g_sz[2].cand;
            ESZ_B64:  new_val = g_sz[3].cand;
            ESZ_FULL: new_val = data;
            ESZ_HALF: new_val[2*HALF_W-1:0] = {{HALF_W{1'b0}}, data[HALF_W-1:0]};
            default:  new_val = old_val;
        endcase
    end

endmodule

// File: rtl/vlane_extract.sv
module vlane_extract
    import vlane_pkg::*;
#(
    parameter int REG_W = 128,
    parameter int IDX_W = 5
) (
    input  logic [REG_W-1:0] word,
    input  logic [2:0]       size,
    input  logic [IDX_W-1:0] idx,
    input  logic             sgn,
    output logic [REG_W-1:0] result
);

    for (genvar g = 0; g < LANE_SIZES; g++) begin : g_sz
        localparam int EW    = 8 << g;
        localparam int LANES = REG_W / EW;
        localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

        logic [LW-1:0]    lane;
        int unsigned      pos;
        logic [EW-1:0]    bits;
        logic [EXT_W-1:0] ext;

        always_comb begin
            lane = idx[LW-1:0];
            pos  = 32'(lane) * EW;
            bits = word[pos +: EW];
            ext  = sgn ? EXT_W'($signed(bits)) : EXT_W'(bits);
        end
    end

    logic [HALF_W-1:0] half_bits;
    logic [EXT_W-1:0]  half_ext;

    always_comb begin
        half_bits = word[HALF_W-1:0];
        half_ext  = sgn ? EXT_W'($signed(half_bits)) : EXT_W'(half_bits);
    end

    always_comb begin
        case (size)
            ESZ_B8:   result = REG_W'(g_sz[0].ext);
            ESZ_B16:  result = REG_W'(g_sz[1].ext);
            ESZ_B32:  result = REG_W'(g_sz[2].ext);
            ESZ_B64:  result = REG_W'(g_sz[3].ext);
            ESZ_FULL: result = word;
            ESZ_HALF: result = REG_W'(half_ext);
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/vlane_file.sv
module vlane_file
    import vlane_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = 128,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int IDX_W   = $clog2(REG_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_reg,
    input  logic [2:0]        wr_size,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    output logic              wr_err,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_reg,
    input  logic [2:0]        rd_size,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_signed,
    output logic [REG_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              rd_err
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] bank;
        logic [REG_W-1:0]               rdat;
        logic                           rvld;
    } state_t;

    state_t st_d, st_q;

    logic             wr_ok, rd_ok;
    logic [REG_W-1:0] wr_old, wr_merged;
    logic [REG_W-1:0] rd_word, rd_lane;

    vlane_bounds #(
        .NUM_REGS(NUM_REGS), .REG_W(REG_W), .REG_AW(REG_AW), .IDX_W(IDX_W)
    ) u_wr_bounds (
        .en(wr_en), .sel(wr_reg), .size(wr_size), .idx(wr_idx),
        .ok(wr_ok), .err(wr_err)
    );

    vlane_bounds #(
        .NUM_REGS(NUM_REGS), .REG_W(REG_W), .REG_AW(REG_AW), .IDX_W(IDX_W)
    ) u_rd_bounds (
        .en(rd_en), .sel(rd_reg), .size(rd_size), .idx(rd_idx),
        .ok(rd_ok), .err(rd_err)
    );

    always_comb begin
        wr_old  = st_q.bank[wr_reg];
        rd_word = st_q.bank[rd_reg];
    end

    vlane_merge #(.REG_W(REG_W), .IDX_W(IDX_W)) u_merge (
        .old_val(wr_old), .size(wr_size), .idx(wr_idx),
        .data(wr_data), .new_val(wr_merged)
    );

    vlane_extract #(.REG_W(REG_W), .IDX_W(IDX_W)) u_extract (
        .word(rd_word), .size(rd_size), .idx(rd_idx),
        .sgn(rd_signed), .result(rd_lane)
    );

    // next-state: the read sees the bank before this cycle's write
    always_comb begin
        st_d      = st_q;
        st_d.rvld = rd_en && rd_ok;
        if (rd_en && rd_ok) begin
            st_d.rdat = rd_lane;
        end
        if (wr_en && wr_ok) begin
            st_d.bank[wr_reg] = wr_merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.rdat;
    assign rd_valid = st_q.rvld;

endmodule

// File: rtl/vlane_file_chk.sv
module vlane_file_chk #(
    parameter int REG_W  = 128,
    parameter int REG_AW = 5,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        wr_size,
    input logic [IDX_W-1:0]  wr_idx,
    input logic              wr_err,
    input logic              rd_en,
    input logic [2:0]        rd_size,
    input logic [REG_W-1:0]  rd_data,
    input logic              rd_valid,
    input logic              rd_err
);

    localparam int unsigned H_LANES = REG_W / 16;

    // R10: a legal read yields valid data on the following edge
    p_valid_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_err) |=> rd_valid);

    // R8: no legal read means no valid data next cycle
    p_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !rd_err) |=> !rd_valid);

    // R8: read data holds when no legal read was accepted
    p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !rd_err) |=> $stable(rd_data));

    // R6: lane reads leave the upper half zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_err && rd_size != 3'd4) |=> (rd_data[REG_W-1:64] == '0));

    // R11: unused size codes are refused on both ports
    p_bad_wsize_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size > 3'd5) |-> wr_err);
    p_bad_rsize_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size > 3'd5) |-> rd_err);

    // R7: 16-bit index beyond the lane count is refused
    p_h_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 3'd1 && 32'(wr_idx) >= H_LANES) |-> wr_err);

    // R7: no error without a request
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err);

endmodule

bind vlane_file vlane_file_chk #(
    .REG_W(REG_W), .REG_AW(REG_AW), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_size(wr_size), .wr_idx(wr_idx), .wr_err(wr_err),
    .rd_en(rd_en), .rd_size(rd_size), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_err(rd_err)
);

// File: tb/tb_vlane_file.sv
module tb_vlane_file;

    localparam int NR = 32;
    localparam int W  = 128;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [4:0]   wr_reg;
    logic [2:0]   wr_size;
    logic [4:0]   wr_idx;
    logic [W-1:0] wr_data;
    logic         wr_err;
    logic         rd_en;
    logic [4:0]   rd_reg;
    logic [2:0]   rd_size;
    logic [4:0]   rd_idx;
    logic         rd_signed;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         rd_err;

    int n_cmp = 0;
    int n_bad = 0;

    logic [W-1:0] mdl [NR];
    logic [W-1:0] last_rd;

    always #10 clk = ~clk;

    vlane_file dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_size(wr_size), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_err(wr_err),
        .rd_en(rd_en), .rd_reg(rd_reg), .rd_size(rd_size), .rd_idx(rd_idx),
        .rd_signed(rd_signed), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_err(rd_err)
    );

    function automatic bit legal(input logic [2:0] sz, input int idx);
        case (sz)
            3'd0: return idx < 16;
            3'd1: return idx < 8;
            3'd2: return idx < 4;
            3'd3: return idx < 2;
            3'd4, 3'd5: return idx == 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [W-1:0] mdl_write(input logic [W-1:0] old, input logic [2:0] sz,
                                                input int idx, input logic [W-1:0] d);
        logic [W-1:0] r = old;
        if (sz <= 3'd3) begin
            int ew = 8 << sz;
            for (int b = 0; b < ew; b++) r[idx*ew + b] = d[b];
        end else if (sz == 3'd4) begin
            r = d;
        end else if (sz == 3'd5) begin
            for (int b = 0; b < 16; b++) r[b] = d[b];
            for (int b = 16; b < 32; b++) r[b] = 1'b0;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] mdl_read(input logic [W-1:0] word, input logic [2:0] sz,
                                               input int idx, input bit sgn);
        logic [W-1:0] r = '0;
        int ew;
        int base;
        if (sz == 3'd4) return word;
        ew   = (sz == 3'd5) ? 16 : (8 << sz);
        base = (sz == 3'd5) ? 0 : idx * ew;
        for (int b = 0; b < 64; b++)
            r[b] = (b < ew) ? word[base + b] : (sgn ? word[base + ew - 1] : 1'b0);
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input string req, input int r, input logic [2:0] sz,
                            input int idx, input logic [W-1:0] d);
        bit ok = legal(sz, idx);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 5'(r); wr_size = sz; wr_idx = 5'(idx); wr_data = d;
        #1;
        check(req, W'(wr_err), W'(!ok));
        @(posedge clk);
        #1 wr_en = 1'b0;
        if (ok) mdl[r] = mdl_write(mdl[r], sz, idx, d);
    endtask

    task automatic do_read(input string req, input int r, input logic [2:0] sz,
                           input int idx, input bit sgn);
        bit ok = legal(sz, idx);
        logic [W-1:0] prev = last_rd;
        @(negedge clk);
        rd_en = 1'b1; rd_reg = 5'(r); rd_size = sz; rd_idx = 5'(idx); rd_signed = sgn;
        #1;
        check(req, W'(rd_err), W'(!ok));
        @(posedge clk);
        #1 rd_en = 1'b0;
        @(negedge clk);
        check(req, W'(rd_valid), W'(ok));
        if (ok) begin
            check(req, rd_data, mdl_read(mdl[r], sz, idx, sgn));
            last_rd = rd_data;
        end else begin
            check(req, rd_data, prev);
        end
    endtask

    task automatic full_check(input string req, input int r);
        do_read(req, r, 3'd4, 0, 1'b0);
    endtask

    task automatic t_reset;
        check("R1 valid low", W'(rd_valid), '0);
        full_check("R1 reg0", 0);
        full_check("R1 reg31", 31);
        check("R1 literal zero", rd_data, '0);
    endtask

    task automatic t_bytes;
        do_write("R2 byte5", 3, 3'd0, 5, W'(8'hA5));
        full_check("R2 byte5 only", 3);
        check("R3 lane5 position", rd_data, W'(128'hA5) << 40);
        do_write("R3 byte0", 3, 3'd0, 0, W'(8'h11));
        do_write("R3 byte15", 3, 3'd0, 15, W'(8'hEE));
        full_check("R3 byte0/15", 3);
        check("R3 msb lane", rd_data, (W'(128'hEE) << 120) | (W'(128'hA5) << 40) | W'(8'h11));
        full_check("R2 neighbour reg untouched", 4);
    endtask

    task automatic t_sizes;
        do_write("R4 half idx7", 8, 3'd1, 7, W'(16'hBEEF));
        do_write("R4 word idx2", 8, 3'd2, 2, W'(32'h1234_5678));
        do_write("R4 dword idx0", 8, 3'd3, 0, W'(64'h0102_0304_0506_0708));
        full_check("R4 combined", 8);
        check("R4 literal", rd_data,
              (W'(16'hBEEF) << 112) | (W'(32'h1234_5678) << 64) | W'(64'h0102_0304_0506_0708));
        do_write("R4 dword idx1", 8, 3'd3, 1, W'(64'hCAFE_0000_F00D_0001));
        do_read("R4 lane read 16", 8, 3'd1, 0, 1'b0);
        full_check("R4 after dword1", 8);
    endtask

    task automatic t_full;
        do_write("R5 full", 12, 3'd4, 0, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);
        do_read("R5 signed ignored", 12, 3'd4, 0, 1'b1);
        check("R5 literal", rd_data, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);
    endtask

    task automatic t_sign;
        do_write("R6 setup byte", 5, 3'd0, 3, W'(8'h80));
        do_read("R6 byte signed", 5, 3'd0, 3, 1'b1);
        check("R6 byte sext", rd_data, W'(64'hFFFF_FFFF_FFFF_FF80));
        do_read("R6 byte unsigned", 5, 3'd0, 3, 1'b0);
        check("R6 byte zext", rd_data, W'(64'h80));
        do_write("R6 setup h", 5, 3'd1, 6, W'(16'h8001));
        do_read("R6 h signed", 5, 3'd1, 6, 1'b1);
        check("R6 h sext", rd_data, W'(64'hFFFF_FFFF_FFFF_8001));
        do_write("R6 setup w", 5, 3'd2, 1, W'(32'h7FFF_FFFF));
        do_read("R6 w signed positive", 5, 3'd2, 1, 1'b1);
        check("R6 w positive", rd_data, W'(64'h7FFF_FFFF));
        do_read("R6 w neg unsigned", 12, 3'd2, 3, 1'b0);
        do_read("R6 w neg signed", 12, 3'd2, 3, 1'b1);
        check("R6 w neg sext", rd_data, W'(64'hFFFF_FFFF_FEDC_BA98));
    endtask

    task automatic t_bounds;
        do_write("R7 byte idx16", 12, 3'd0, 16, '1);
        do_write("R7 h idx8", 12, 3'd1, 8, '1);
        do_write("R7 w idx4", 12, 3'd2, 4, '1);
        do_write("R7 d idx2", 12, 3'd3, 2, '1);
        do_write("R7 full idx1", 12, 3'd4, 1, '1);
        do_write("R7 half idx1", 12, 3'd5, 1, '1);
        full_check("R7 contents unchanged", 12);
        check("R7 literal unchanged", rd_data, 128'hFEDC_BA98_7654_3210_0F1E_2D3C_4B5A_6978);
        do_write("R7 d idx1 legal", 20, 3'd3, 1, W'(64'h55));
        full_check("R7 legal boundary", 20);
        @(negedge clk);
        check("R7 idle no err", W'(wr_err), '0);
    endtask

    task automatic t_bad_read;
        do_read("R8 good read", 3, 3'd0, 5, 1'b0);
        do_read("R8 byte idx16", 3, 3'd0, 16, 1'b0);
        do_read("R8 d idx3", 3, 3'd3, 3, 1'b1);
        check("R8 held literal", rd_data, W'(8'hA5));
    endtask

    task automatic t_half;
        do_write("R9 fill", 9, 3'd4, 0, '1);
        do_write("R9 half", 9, 3'd5, 0, 128'hAAAA_AAAA_AAAA_AAAA_AAAA_AAAA_9999_1234);
        full_check("R9 half layout", 9);
        check("R9 literal", rd_data, {{96{1'b1}}, 16'h0000, 16'h1234});
        do_write("R9 half neg", 9, 3'd5, 0, W'(16'hF00F));
        do_read("R9 half read signed", 9, 3'd5, 0, 1'b1);
        check("R9 read sext", rd_data, W'(64'hFFFF_FFFF_FFFF_F00F));
    endtask

    task automatic t_same_cycle;
        logic [W-1:0] old_v = mdl[20];
        logic [W-1:0] nv = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 5'd20; wr_size = 3'd4; wr_idx = '0; wr_data = nv;
        rd_en = 1'b1; rd_reg = 5'd20; rd_size = 3'd4; rd_idx = '0; rd_signed = 1'b0;
        @(posedge clk);
        #1 wr_en = 1'b0; rd_en = 1'b0;
        mdl[20] = nv;
        @(negedge clk);
        check("R10 valid one cycle later", W'(rd_valid), W'(1'b1));
        check("R10 old contents", rd_data, old_v);
        last_rd = rd_data;
        full_check("R10 new contents", 20);
        check("R10 literal new", rd_data, nv);
    endtask

    task automatic t_bad_size;
        do_write("R11 wsize6", 9, 3'd6, 0, '0);
        do_write("R11 wsize7", 9, 3'd7, 0, '0);
        do_read("R11 rsize6", 9, 3'd6, 0, 1'b0);
        do_read("R11 rsize7", 9, 3'd7, 0, 1'b0);
        full_check("R11 unchanged", 9);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) mdl[i] = '0;
        last_rd = '0;
        rst_n = 1'b0;
        wr_en = 1'b0; wr_reg = '0; wr_size = '0; wr_idx = '0; wr_data = '0;
        rd_en = 1'b0; rd_reg = '0; rd_size = '0; rd_idx = '0; rd_signed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_sizes();
        t_full();
        t_sign();
        t_bounds();
        t_bad_read();
        t_half();
        t_same_cycle();
        t_bad_size();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule